// File: doc/BRIEF.md
# TDM Slot Transmitter

This block is a serial audio output port for a shared time-division multiplexed data line. It is a clock slave: the host supplies the bit clock and the frame sync, and the port oversamples both on its own system clock. Two parallel sample channels are presented on its inputs. At every frame start the port captures both samples and the whole configuration. It then serialises each sample into the slot that the configuration chose for that channel.

The slot width equals the programmed word length, which is 16, 20, 24 or 32 bits. A sample wider than the word loses its low bits. A narrower sample is followed by zero bits. The port drives an output-enable only while one of its own slots is on the line. Several ports with disjoint slot indices can therefore share one data wire, with the bit clock rate sized to channels × devices × word length per frame.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset, `sdout` and `sdout_oe` are 0, and they stay 0 until the first frame start has been seen.
- R2: A frame starts on the bit-clock rising edge where `fsync` is sampled 1 after it was sampled 0 on the previous rising edge. A sync held high for several bit clocks starts only one frame. Bit position 0 of the frame is driven on the very next falling edge of the bit clock, one bit clock after the sync was sampled.
- R3: `sdout` and `sdout_oe` change only on falling edges of the bit clock, and each slot is sent MSB first.
- R4: `word_len` selects the slot width W: 0 = 16, 1 = 20, 2 = 24, 3 = 32. Slot n covers frame bit positions n·W through n·W+W−1.
- R5: When W is smaller than SAMPLE_W, the slot carries the W most significant sample bits, and the rest of the sample is dropped.
- R6: When W is larger than SAMPLE_W, the bits of the slot after the last sample bit are 0.
- R7: Each channel has its own 6-bit slot index, 0 to 63. `sdout_oe` is 1 for exactly the bit positions of the slots assigned to the channels.
- R8: While `sdout_oe` is 0, `sdout` is 0.
- R9: When both channels hold the same slot index, that slot carries channel 1.
- R10: The samples, the slot indices and `word_len` are captured at frame start. Changing them during a frame has no effect until the next frame.
- R11: A new frame start restarts the count at position 0, even in the middle of a slot. Slots that lie beyond the end of the frame are not sent, and after slot 63 nothing more is driven in that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Host bit clock, synchronous to clk and at most clk/4 |
| fsync | input | 1 | Host frame sync |
| ch1_sample | input | SAMPLE_W | Channel 1 sample |
| ch2_sample | input | SAMPLE_W | Channel 2 sample |
| word_len | input | 2 | Word length code (R4) |
| ch1_slot | input | SLOT_IDX_W | Slot index for channel 1 |
| ch2_slot | input | SLOT_IDX_W | Slot index for channel 2 |
| sdout | output | 1 | Serial data toward the shared line |
| sdout_oe | output | 1 | High while this port owns the line |

## Verification
The bench drives frames whose lengths are not multiples of the slot width. It places a slot past the end of a frame and one at index 63 with 16-bit words. A counter that wraps or fails to restart would emit data in slots it does not own, or it would miss slot 63. Both channels are given the same slot, which exposes a reversed priority as channel 2 data appearing in that slot. The bench uses all four word lengths with a 24-bit sample, so a sender that drops the wrong bits when truncating, or that pads with stale bits, shows mismatching tail bits. The inputs are also rewritten in the middle of a frame and a wide sync pulse is sent. A port that does not capture at the frame boundary changes its data partway through the frame, and a port that detects the sync by level starts the frame again.

// File: rtl/tdm_pkg.sv
// Shared types and helpers for the TDM slot transmitter.
// Assumes word length codes are fixed at two bits.
package tdm_pkg;

    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_20 = 2'd1,
        WL_24 = 2'd2,
        WL_32 = 2'd3
    } wlen_e;

    // Index of the last bit inside a slot for a given word length.
    function automatic logic [4:0] wlen_last(input wlen_e wl);
        case (wl)
            WL_16:   return 5'd15;
            WL_20:   return 5'd19;
            WL_24:   return 5'd23;
            default: return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/tdm_edge_detect.sv
// Oversamples the host bit clock and frame sync on the system clock.
// It produces one-cycle pulses for bit-clock rising and falling edges and
// a frame-start pulse when the sync goes from low to high between two
// bit-clock rising edges. It assumes that bclk and fsync are already
// synchronous to clk.
module tdm_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic frame_start
);

    logic bclk_q;
    logic fs_q;

    // Remember the previous bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk;
    end

    assign bclk_rise = bclk & ~bclk_q;
    assign bclk_fall = ~bclk & bclk_q;

    // Keep the sync value sampled at the last bit-clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         fs_q <= 1'b0;
        else if (bclk_rise) fs_q <= fsync;
    end

    assign frame_start = bclk_rise & fsync & ~fs_q;

    // A frame start must never follow another with no low sync in between.
    p_single_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

endmodule

// File: rtl/tdm_frame_latch.sv
// Captures both samples, both slot indices and the word length at frame
// start, so the frame is sent from values that cannot change during it.
module tdm_frame_latch #(
    parameter int SAMPLE_W   = 24,
    parameter int SLOT_IDX_W = 6,
    parameter int NCH        = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  frame_start,
    input  logic [NCH-1:0][SAMPLE_W-1:0]          smp_in,
    input  logic [NCH-1:0][SLOT_IDX_W-1:0]        slot_in,
    input  logic [1:0]                            wlen_in,
    output logic [NCH-1:0][SAMPLE_W-1:0]          smp_lat,
    output logic [NCH-1:0][SLOT_IDX_W-1:0]        slot_lat,
    output tdm_pkg::wlen_e                        wlen_lat
);

    // Take a snapshot of the inputs on every frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_lat  <= '0;
            slot_lat <= '0;
            wlen_lat <= tdm_pkg::WL_16;
        end else if (frame_start) begin
            smp_lat  <= smp_in;
            slot_lat <= slot_in;
            wlen_lat <= tdm_pkg::wlen_e'(wlen_in);
        end
    end

    p_hold_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(smp_lat) && $stable(slot_lat) && $stable(wlen_lat)));

endmodule

// File: rtl/tdm_slot_counter.sv
// Tracks the frame position that the next bit-clock falling edge will
// drive, as a slot index plus a bit offset inside the slot. It resets on a
// frame start and advances on every later bit-clock rising edge. The slot
// index saturates at 2**SLOT_IDX_W, which means past the last slot.
module tdm_slot_counter #(
    parameter int SLOT_IDX_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bclk_rise,
    input  logic                  frame_start,
    input  tdm_pkg::wlen_e        wlen,
    output logic                  active,
    output logic [SLOT_IDX_W:0]   slot_idx,
    output logic [4:0]            bit_idx
);

    localparam logic [SLOT_IDX_W:0] SLOT_END = {1'b1, {SLOT_IDX_W{1'b0}}};

    logic [4:0] last_bit;
    assign last_bit = tdm_pkg::wlen_last(wlen);

    // Restart at frame start; otherwise step one bit per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            slot_idx <= '0;
            bit_idx  <= '0;
        end else if (frame_start) begin
            active   <= 1'b1;
            slot_idx <= '0;
            bit_idx  <= '0;
        end else if (bclk_rise && active) begin
            if (bit_idx == last_bit) begin
                bit_idx <= '0;
                if (slot_idx != SLOT_END) slot_idx <= slot_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (active && slot_idx == '0 && bit_idx == '0));
    p_bit_in_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_idx <= last_bit));
    p_slot_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= SLOT_END);

endmodule

// File: rtl/tdm_lane_select.sv
// For the current frame position, finds the channel that owns the slot,
// with the lowest channel index winning a tie. It returns an enable and the
// data bit: MSB first, and zero once the slot runs past the sample width.
module tdm_lane_select #(
    parameter int SAMPLE_W   = 24,
    parameter int SLOT_IDX_W = 6,
    parameter int NCH        = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            active,
    input  logic [SLOT_IDX_W:0]             slot_idx,
    input  logic [4:0]                      bit_idx,
    input  logic [NCH-1:0][SAMPLE_W-1:0]    smp,
    input  logic [NCH-1:0][SLOT_IDX_W-1:0]  slot_cfg,
    output logic                            drive_en,
    output logic                            drive_bit
);

    localparam int SEL_W = $clog2(SAMPLE_W);

    logic [NCH-1:0] hit;
    logic [NCH-1:0] lane_bit;
    logic           in_sample;
    logic [SEL_W-1:0] sel;

    assign in_sample = int'(bit_idx) < SAMPLE_W;
    assign sel       = SEL_W'(SAMPLE_W - 1) - SEL_W'(bit_idx);

    // Per-channel slot match and bit pick.
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        assign hit[c]      = active && (slot_idx == {1'b0, slot_cfg[c]});
        assign lane_bit[c] = in_sample ? smp[c][sel] : 1'b0;
    end

    // Priority pick: scan from the highest channel so the lowest one wins.
    always_comb begin
        drive_en  = 1'b0;
        drive_bit = 1'b0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (hit[c]) begin
                drive_en  = 1'b1;
                drive_bit = lane_bit[c];
            end
        end
    end

    p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && !in_sample) |-> !drive_bit);
    p_owner_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (active && slot_idx[SLOT_IDX_W] == 1'b0));

endmodule

// File: rtl/tdm_slot_tx.sv
// Top of the TDM slot transmitter. It serialises two sample channels into
// programmable slots of a host-clocked TDM frame. The output register is
// loaded only on bit-clock falling edges. Assumes bclk is synchronous to
// clk with high and low phases of at least two clk cycles each.
module tdm_slot_tx #(
    parameter int SAMPLE_W   = 24,
    parameter int SLOT_IDX_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bclk,
    input  logic                  fsync,
    input  logic [SAMPLE_W-1:0]   ch1_sample,
    input  logic [SAMPLE_W-1:0]   ch2_sample,
    input  logic [1:0]            word_len,
    input  logic [SLOT_IDX_W-1:0] ch1_slot,
    input  logic [SLOT_IDX_W-1:0] ch2_slot,
    output logic                  sdout,
    output logic                  sdout_oe
);

    localparam int NCH = 2;

    logic bclk_rise, bclk_fall, frame_start;
    logic [NCH-1:0][SAMPLE_W-1:0]   smp_lat;
    logic [NCH-1:0][SLOT_IDX_W-1:0] slot_lat;
    tdm_pkg::wlen_e                 wlen_lat;
    logic                 cnt_active;
    logic [SLOT_IDX_W:0]  slot_idx;
    logic [4:0]           bit_idx;
    logic                 drive_en, drive_bit;

    tdm_edge_detect u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk        (bclk),
        .fsync       (fsync),
        .bclk_rise   (bclk_rise),
        .bclk_fall   (bclk_fall),
        .frame_start (frame_start)
    );

    tdm_frame_latch #(.SAMPLE_W(SAMPLE_W), .SLOT_IDX_W(SLOT_IDX_W), .NCH(NCH)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .smp_in      ({ch2_sample, ch1_sample}),
        .slot_in     ({ch2_slot, ch1_slot}),
        .wlen_in     (word_len),
        .smp_lat     (smp_lat),
        .slot_lat    (slot_lat),
        .wlen_lat    (wlen_lat)
    );

    tdm_slot_counter #(.SLOT_IDX_W(SLOT_IDX_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_rise   (bclk_rise),
        .frame_start (frame_start),
        .wlen        (wlen_lat),
        .active      (cnt_active),
        .slot_idx    (slot_idx),
        .bit_idx     (bit_idx)
    );

    tdm_lane_select #(.SAMPLE_W(SAMPLE_W), .SLOT_IDX_W(SLOT_IDX_W), .NCH(NCH)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (cnt_active),
        .slot_idx    (slot_idx),
        .bit_idx     (bit_idx),
        .smp         (smp_lat),
        .slot_cfg    (slot_lat),
        .drive_en    (drive_en),
        .drive_bit   (drive_bit)
    );

    // Launch the next line bit on each bit-clock falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdout    <= 1'b0;
            sdout_oe <= 1'b0;
        end else if (bclk_fall) begin
            sdout_oe <= drive_en;
            sdout    <= drive_en & drive_bit;
        end
    end

    p_release_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sdout_oe |-> !sdout);
    p_change_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_fall |=> ($stable(sdout) && $stable(sdout_oe)));
    p_quiet_before_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_active |=> !sdout_oe);

endmodule

// File: tb/test_tdm_slot_tx.sv
`timescale 1ns/1ps
module test_tdm_slot_tx;

    localparam int SW = 24;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0;
    logic fsync = 1'b0;
    logic [SW-1:0] ch1_sample = '0, ch2_sample = '0;
    logic [1:0]    word_len = 2'd0;
    logic [IW-1:0] ch1_slot = '0, ch2_slot = '0;
    logic sdout, sdout_oe;

    int n_cmp = 0;
    int n_bad = 0;

    // Model of what the port captured at the last frame start.
    int          m_w;
    int          m_s1, m_s2;
    logic [SW-1:0] m_d1, m_d2;

    always #10 clk = ~clk;

    tdm_slot_tx #(.SAMPLE_W(SW), .SLOT_IDX_W(IW)) i_tdm_slot_tx (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .ch1_sample(ch1_sample), .ch2_sample(ch2_sample), .word_len(word_len),
        .ch1_slot(ch1_slot), .ch2_slot(ch2_slot),
        .sdout(sdout), .sdout_oe(sdout_oe)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung (actual running, expected finished)");
        summary();
        $finish;
    end

    task automatic check(input string tag, input int pos,
                         input logic a_oe, input logic a_d,
                         input logic e_oe, input logic e_d);
        n_cmp++;
        if (a_oe !== e_oe || a_d !== e_d) begin
            n_bad++;
            $display("FAIL %s pos %0d: actual oe=%b d=%b expected oe=%b d=%b",
                     tag, pos, a_oe, a_d, e_oe, e_d);
        end
    endtask

    function automatic int code_to_w(input logic [1:0] c);
        case (c)
            2'd0: return 16;
            2'd1: return 20;
            2'd2: return 24;
            default: return 32;
        endcase
    endfunction

    // Expected {oe, data} for a frame bit position.
    function automatic logic [1:0] exp_pair(input int p);
        int slot, b;
        logic [SW-1:0] d;
        slot = p / m_w;
        b    = p % m_w;
        if (slot >= 64) return 2'b00;
        if (slot == m_s1)      d = m_d1;
        else if (slot == m_s2) d = m_d2;
        else return 2'b00;
        if (b < SW) return {1'b1, d[SW-1-b]};
        return 2'b10;
    endfunction

    task automatic set_cfg(input logic [1:0] wc, input int s1, input int s2,
                           input logic [SW-1:0] d1, input logic [SW-1:0] d2);
        word_len = wc; ch1_slot = IW'(s1); ch2_slot = IW'(s2);
        ch1_sample = d1; ch2_sample = d2;
        m_w = code_to_w(wc); m_s1 = s1; m_s2 = s2; m_d1 = d1; m_d2 = d2;
    endtask

    // One bit clock: high for two clk cycles, then low for two. It returns the
    // outputs seen during the high phase.
    task automatic tick(input logic fs, output logic mid_oe, output logic mid_d);
        @(negedge clk); bclk = 1'b1; fsync = fs;
        @(negedge clk); mid_oe = sdout_oe; mid_d = sdout;
        @(negedge clk); bclk = 1'b0;
        @(negedge clk);
    endtask

    // Runs a frame of nbits bit clocks and checks every position. The sync
    // is high for fs_len clocks. At chg_at the inputs are scrambled.
    task automatic run_frame(input int nbits, input string tag,
                             input int fs_len, input int chg_at);
        logic mo, md, po, pd;
        logic [1:0] e;
        po = sdout_oe; pd = sdout;
        for (int p = 0; p < nbits; p++) begin
            tick(p < fs_len, mo, md);
            // R3: nothing moves while the bit clock is high.
            check("R3", p, mo, md, po, pd);
            if (p == chg_at) begin
                ch1_sample = ~ch1_sample; ch2_sample = $urandom();
                ch1_slot = ch1_slot + 1'b1; ch2_slot = ch2_slot + 2'd3;
                word_len = word_len + 1'b1;
            end
            e = exp_pair(p);
            check(tag, p, sdout_oe, sdout, e[1], e[0]);
            po = sdout_oe; pd = sdout;
        end
    endtask

    initial begin
        logic mo, md;
        void'($urandom(32'h5EED_1234));
        m_w = 16; m_s1 = 0; m_s2 = 0; m_d1 = '0; m_d2 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 0, sdout_oe, sdout, 1'b0, 1'b0);

        // R1: bit clocks with no sync leave the line released.
        set_cfg(2'd2, 0, 1, 24'hFFFFFF, 24'hFFFFFF);
        for (int i = 0; i < 6; i++) begin
            tick(1'b0, mo, md);
            check("R1", i, sdout_oe, sdout, 1'b0, 1'b0);
        end

        // R2, R6: 32-bit slots padded after a 24-bit sample, slots 0 and 1.
        set_cfg(2'd3, 0, 1, 24'hA5C3_96, 24'h5A3C_69);
        run_frame(256, "R2", 1, -1);
        // R5: 16-bit slots keep only the top sample bits.
        set_cfg(2'd0, 3, 5, 24'hBEEF_57, 24'h1234_AB);
        run_frame(128, "R5", 1, -1);
        // R9: both channels on slot 2, channel 1 must win.
        set_cfg(2'd1, 2, 2, 24'hF0F0_F0, 24'h0F0F_0F);
        run_frame(160, "R9", 1, -1);
        // R10: inputs rewritten during the frame.
        set_cfg(2'd2, 1, 4, 24'hC0FF_EE, 24'h8BAD_F0);
        run_frame(192, "R10", 1, 10);
        // R11: frame cut partway through slot 7; the next frame restarts.
        set_cfg(2'd2, 7, 3, 24'h7654_32, 24'h9ABC_DE);
        run_frame(7 * 24 + 5, "R11", 1, -1);
        set_cfg(2'd2, 7, 3, 24'h1357_9B, 24'h2468_AC);
        run_frame(192, "R11", 1, -1);
        // R7, R11: slot 63 at 16 bits, then nothing past the last slot.
        set_cfg(2'd0, 10, 63, 24'hD00D_1E, 24'hCAFE_42);
        run_frame(1100, "R7", 1, -1);
        // R2: a sync held high for three bit clocks starts a single frame.
        set_cfg(2'd1, 0, 6, 24'h1111_EE, 24'hEEEE_11);
        run_frame(160, "R2", 3, -1);
        // R8: a frame where neither slot appears keeps the line released.
        set_cfg(2'd0, 40, 50, 24'hFFFF_FF, 24'hFFFF_FF);
        run_frame(128, "R8", 1, -1);

        // R4: random word lengths, slots, samples and frame lengths.
        for (int f = 0; f < 30; f++) begin
            logic [1:0] wc;
            int ns;
            wc = 2'($urandom_range(3));
            ns = $urandom_range(10, 2);
            set_cfg(wc, $urandom_range(11), $urandom_range(11),
                    SW'($urandom()), SW'($urandom()));
            run_frame(ns * code_to_w(wc) + $urandom_range(3), "R4", 1, -1);
        end

        summary();
        $finish;
    end

endmodule